// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous burst static memory whose words are split into byte lanes, each lane holding eight data bits and one parity bit. Every control input, the address and the write data are sampled on the rising clock edge. Two address strobes start a burst: a processor-side strobe that always starts a read, and a controller-side strobe that starts either a read or a write. When neither strobe is active, an advance input either steps a 2-bit burst counter or holds the current address. The counter steps through the four words of an aligned group, in linear or interleaved order.

Reads are flow-through. The word at the registered address is driven combinationally in the cycle that follows the capturing edge, with no output register. Writes can be masked per lane through a lane-enable group qualified by a common lane-write enable, or can cover every lane through a global write input. Output drive is gated by an asynchronous active-low output enable and by an active-high sleep input. The bidirectional data bus is split into separate write-data, read-data and drive-enable signals.

Top module: `sbs_burst_sram`

## Requirements
- R1: After reset the read-data drive enable `rd_drive` is low and no burst is active.
- R2: With `proc_strobe_n` low and all three chip selects active, the address is captured and a read begins, whatever the write inputs are. `rd_data` holds the word at that address in the cycle after the edge.
- R3: `proc_strobe_n` is ignored while `chip_sel_n` is high. In that case a low `ctrl_strobe_n` deselects, and with `ctrl_strobe_n` high the cycle acts as a continue or suspend cycle.
- R4: A low strobe that is honoured deselects when `bank_sel_n` is high or `bank_sel` is low. Output drive then stops, and later continue or suspend cycles perform no access until a new start.
- R5: With `ctrl_strobe_n` low, no honoured processor strobe and all selects active, the address is captured. A write is performed if the decoded write is active; otherwise a read is performed.
- R6: With both strobes high and `step_n` low, the burst counter advances and the chip selects are don't-care. The low two address bits are (start + count) mod 4 when `burst_linear` is 1, and start XOR count when it is 0. The upper bits stay fixed.
- R7: With both strobes high and `step_n` high, the address is held and the access repeats at it.
- R8: The decoded write is active when `wr_all_n` is low, or when `lane_wr_en_n` is low and any bit of `lane_sel_n` is low. `wr_all_n` low writes every lane.
- R9: Lane k is word bits [9k+8:9k]. Bit k of `lane_sel_n` selects lane k for writing, and only while `lane_wr_en_n` is low.
- R10: A write after a processor-strobe start is done by asserting the write inputs in the next suspend or continue cycle. The write goes to the burst address of that cycle.
- R11: `rd_drive` is high only when the last sampled access was a read, `out_en_n` is low and `sleep` is low. `out_en_n` acts without a clock edge.
- R12: While `sleep` is high at an edge, no access happens and the burst address is held. `rd_drive` stays low until the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_in | input | ADDR_W | Word address captured on a start |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| chip_sel_n | input | 1 | Primary chip select, active low, gates the processor strobe |
| bank_sel_n | input | 1 | Secondary chip select, active low |
| bank_sel | input | 1 | Tertiary chip select, active high |
| step_n | input | 1 | Burst advance, active low; high holds the address |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Qualifier for the per-lane write selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| wr_data | input | LANES*LANE_W | Write data, sampled on the edge |
| rd_data | output | LANES*LANE_W | Read word at the registered address |
| rd_drive | output | 1 | High when the data bus would be driven |

## Verification
The bench builds the block with ADDR_W = 4, a 16-word array, and keeps the lane count and lane width at their defaults. With 16 words, a reference copy of the whole array can be kept in the bench and every word filled and read back. Every start offset of every group can be tried in both burst orders, and all sixteen lane-select patterns can be swept at one address, so each step and each lane merge can be predicted arithmetically.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_SLEEP   = 3'd0,
        OP_DESEL   = 3'd1,
        OP_START_P = 3'd2,
        OP_START_C = 3'd3,
        OP_CONT    = 3'd4,
        OP_SUSP    = 3'd5
    } sbs_op_e;

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             chip_sel_n,
    input  logic             bank_sel_n,
    input  logic             bank_sel,
    input  logic             step_n,
    input  logic             sleep,
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output sbs_op_e          op,
    output logic             wr_dec,
    output logic [LANES-1:0] lane_we
);

    logic banks_ok;

    // lane k is written on a global write, or when qualified and selected
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !wr_all_n || (!lane_wr_en_n && !lane_sel_n[g]);
    end

    assign wr_dec   = |lane_we;
    assign banks_ok = !bank_sel_n && bank_sel;

    always_comb begin
        if (sleep) begin
            op = OP_SLEEP;
        end else if (!proc_strobe_n && !chip_sel_n) begin
            // processor strobe honoured only with the primary select low
            op = banks_ok ? OP_START_P : OP_DESEL;
        end else if (!ctrl_strobe_n) begin
            op = (!chip_sel_n && banks_ok) ? OP_START_C : OP_DESEL;
        end else begin
            op = step_n ? OP_SUSP : OP_CONT;
        end
    end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
    parameter int ADDR_W = 6,
    localparam int HI_W  = ADDR_W - 2
) (
    input  logic [HI_W-1:0]   grp,
    input  logic [1:0]        start_lo,
    input  logic [1:0]        count,
    input  logic              linear,
    output logic [ADDR_W-1:0] word_addr
);

    logic [1:0] lo;

    always_comb begin
        if (linear) lo = 2'(start_lo + count);
        else        lo = start_lo ^ count;
        word_addr = {grp, lo};
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_we[g]) begin
                cells[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/sbs_burst_sram.sv
module sbs_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int HI_W   = ADDR_W - 2,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              chip_sel_n,
    input  logic              bank_sel_n,
    input  logic              bank_sel,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic              burst_linear,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);

    typedef struct packed {
        logic [HI_W-1:0] grp;
        logic [1:0]      start_lo;
        logic [1:0]      count;
        logic            active;
        logic            rd;
    } burst_st_t;

    burst_st_t          st_d, st_q;
    sbs_op_e            op;
    logic               wr_dec;
    logic [LANES-1:0]   lane_we;
    logic               mem_we;
    logic [ADDR_W-1:0]  rd_addr;
    logic [ADDR_W-1:0]  wr_addr;
    logic               burst_active;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_sel_n    (chip_sel_n),
        .bank_sel_n    (bank_sel_n),
        .bank_sel      (bank_sel),
        .step_n        (step_n),
        .sleep         (sleep),
        .wr_all_n      (wr_all_n),
        .lane_wr_en_n  (lane_wr_en_n),
        .lane_sel_n    (lane_sel_n),
        .op            (op),
        .wr_dec        (wr_dec),
        .lane_we       (lane_we)
    );

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        unique case (op)
            OP_SLEEP: begin
                st_d.rd = 1'b0;
            end
            OP_DESEL: begin
                st_d.active = 1'b0;
                st_d.rd     = 1'b0;
            end
            OP_START_P: begin
                st_d.grp      = addr_in[ADDR_W-1:2];
                st_d.start_lo = addr_in[1:0];
                st_d.count    = 2'd0;
                st_d.active   = 1'b1;
                st_d.rd       = 1'b1;
            end
            OP_START_C: begin
                st_d.grp      = addr_in[ADDR_W-1:2];
                st_d.start_lo = addr_in[1:0];
                st_d.count    = 2'd0;
                st_d.active   = 1'b1;
                st_d.rd       = !wr_dec;
                mem_we        = wr_dec;
            end
            OP_CONT: begin
                if (st_q.active) begin
                    st_d.count = 2'(st_q.count + 2'd1);
                    st_d.rd    = !wr_dec;
                    mem_we     = wr_dec;
                end else begin
                    st_d.rd = 1'b0;
                end
            end
            OP_SUSP: begin
                if (st_q.active) begin
                    st_d.rd = !wr_dec;
                    mem_we  = wr_dec;
                end else begin
                    st_d.rd = 1'b0;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // address of the access sampled now (write target)
    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_nxt_addr (
        .grp       (st_d.grp),
        .start_lo  (st_d.start_lo),
        .count     (st_d.count),
        .linear    (burst_linear),
        .word_addr (wr_addr)
    );

    // registered address feeding the flow-through read
    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_cur_addr (
        .grp       (st_q.grp),
        .start_lo  (st_q.start_lo),
        .count     (st_q.count),
        .linear    (burst_linear),
        .word_addr (rd_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (mem_we),
        .lane_we (lane_we),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );

    assign burst_active = st_q.active;
    assign rd_drive     = st_q.rd && !out_en_n && !sleep;

endmodule

// File: rtl/sbs_burst_sram_chk.sv
module sbs_burst_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              chip_sel_n,
    input logic              bank_sel_n,
    input logic              bank_sel,
    input logic              step_n,
    input logic              wr_all_n,
    input logic              out_en_n,
    input logic              sleep,
    input logic              burst_linear,
    input logic              rd_drive,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              burst_active,
    input logic              mem_we
);

    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !proc_strobe_n && !chip_sel_n && !bank_sel_n && bank_sel)
        |=> (rd_drive || out_en_n || sleep));

    assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && chip_sel_n && !ctrl_strobe_n) |=> !rd_drive);

    assert_bank_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ctrl_strobe_n && (bank_sel_n || !bank_sel)) |=> !rd_drive);

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && burst_active && proc_strobe_n && ctrl_strobe_n && !step_n && burst_linear)
        |=> (!burst_linear ||
             (rd_addr[1:0] == 2'($past(rd_addr[1:0]) + 2'd1) &&
              rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2]))));

    assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && proc_strobe_n && ctrl_strobe_n && step_n)
        |=> ($stable(rd_addr) || !$stable(burst_linear)));

    assert_write_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && proc_strobe_n && !wr_all_n) |=> !rd_drive);

    assert_sleep_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !mem_we);

    assert_sleep_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(rd_addr) || !$stable(burst_linear)));

endmodule

bind sbs_burst_sram sbs_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_sel_n    (chip_sel_n),
    .bank_sel_n    (bank_sel_n),
    .bank_sel      (bank_sel),
    .step_n        (step_n),
    .wr_all_n      (wr_all_n),
    .out_en_n      (out_en_n),
    .sleep         (sleep),
    .burst_linear  (burst_linear),
    .rd_drive      (rd_drive),
    .rd_addr       (rd_addr),
    .burst_active  (burst_active),
    .mem_we        (mem_we)
);

// File: tb/sbs_burst_sram_tb.sv
module sbs_burst_sram_tb;

    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] a = '0;
    logic          p_n, c_n, cs_n, bk_n, bk, st_n, ga_n, le_n;
    logic [3:0]    ls_n;
    logic          oe_n = 1'b0;
    logic          slp, lin = 1'b1;
    logic [35:0]   wd = '0;
    logic [35:0]   rdd;
    logic          drv;

    logic [35:0]   ref_mem [WORDS];
    int            n_chk = 0;
    int            n_fail = 0;
    int            cycles = 0;

    always #10 clk = ~clk;

    sbs_burst_sram #(.ADDR_W(AW)) u_dut (
        .clk (clk), .rst_n (rst_n), .addr_in (a),
        .proc_strobe_n (p_n), .ctrl_strobe_n (c_n),
        .chip_sel_n (cs_n), .bank_sel_n (bk_n), .bank_sel (bk),
        .step_n (st_n), .wr_all_n (ga_n), .lane_wr_en_n (le_n),
        .lane_sel_n (ls_n), .out_en_n (oe_n), .sleep (slp),
        .burst_linear (lin), .wr_data (wd), .rd_data (rdd), .rd_drive (drv)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [35:0] pat(int v);
        return {4'(v * 5 + 3), 32'(v * 32'h9E3779B1 + 32'h0135_79BD)};
    endfunction

    function automatic int baddr(int base, int s, int k, logic l);
        return (base & ~3) | (l ? ((s + k) & 3) : (s ^ k));
    endfunction

    task automatic idle();
        p_n = 1; c_n = 1; cs_n = 0; bk_n = 0; bk = 1; st_n = 1;
        ga_n = 1; le_n = 1; ls_n = 4'hF; slp = 0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_off(string r);
        n_chk++;
        if (drv !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: drive=%b expected drive=0", r, drv);
        end
    endtask

    task automatic chk_rd(string r, int adr);
        n_chk++;
        if (drv !== 1'b1 || rdd !== ref_mem[adr]) begin
            n_fail++;
            $display("FAIL %s: drive=%b data=%h expected drive=1 data=%h",
                     r, drv, rdd, ref_mem[adr]);
        end
    endtask

    task automatic proc_rd(int adr);
        idle(); p_n = 0; a = AW'(adr); ga_n = 0; tick(); idle();
    endtask

    task automatic ctrl_wr(int adr, logic [35:0] d);
        idle(); c_n = 0; a = AW'(adr); ga_n = 0; wd = d; tick();
        ref_mem[adr] = d; idle();
    endtask

    initial begin
        idle();
        repeat (3) tick();
        chk_off("R1 reset");
        rst_n = 1;
        tick();
        chk_off("R1 after reset idle");

        // R5/R8: fill every word with controller-started global-write bursts
        lin = 1;
        for (int g = 0; g < WORDS / 4; g++) begin
            ctrl_wr(g * 4, pat(g * 4));
            chk_off("R5 write start no drive");
            for (int k = 1; k < 4; k++) begin
                idle(); st_n = 0; ga_n = 0; wd = pat(g * 4 + k);
                cs_n = 1; bk = 0;                // selects are don't-care (R6)
                tick();
                ref_mem[g * 4 + k] = wd;
                chk_off("R8 burst write no drive");
            end
        end
        idle();

        // R2: single reads with write inputs asserted
        for (int i = 0; i < WORDS; i++) begin
            proc_rd(i);
            chk_rd("R2 proc read", i);
        end

        // R6: burst reads from every start, both orders
        for (int m = 0; m < 2; m++) begin
            lin = m[0];
            for (int s0 = 0; s0 < WORDS; s0++) begin
                proc_rd(s0);
                chk_rd("R6 burst first", s0);
                for (int k = 1; k < 4; k++) begin
                    idle(); st_n = 0; cs_n = k[0]; bk_n = k[1];
                    tick();
                    chk_rd(lin ? "R6 linear step" : "R6 interleaved step",
                           baddr(s0, s0 & 3, k, lin));
                end
            end
        end

        // R6: interleaved burst write from offset 2 of group 1
        lin = 0;
        ctrl_wr(6, pat(60));
        for (int k = 1; k < 4; k++) begin
            idle(); st_n = 0; ga_n = 0; wd = pat(60 + k); tick();
            ref_mem[baddr(6, 2, k, 1'b0)] = wd;
        end
        idle();
        for (int i = 4; i < 8; i++) begin
            proc_rd(i);
            chk_rd("R6 interleaved write order", i);
        end
        lin = 1;

        // R7: suspend keeps the address
        proc_rd(9);
        for (int k = 0; k < 3; k++) begin
            idle(); tick();
            chk_rd("R7 suspend hold", 9);
        end

        // R8/R9: sweep every lane-select pattern at word 5
        for (int m = 0; m < 16; m++) begin
            idle(); c_n = 0; a = 4'd5; le_n = 0; ls_n = 4'(m); wd = pat(200 + m);
            tick();
            if (m == 15) chk_rd("R8 no lane selected is read", 5);
            else begin
                chk_off("R8 lane write no drive");
                for (int l = 0; l < 4; l++)
                    if (!m[l]) ref_mem[5][l*9 +: 9] = wd[l*9 +: 9];
            end
            proc_rd(5);
            chk_rd("R9 lane merge", 5);
        end
        // R9: lane selects without the qualifier do not write
        idle(); c_n = 0; a = 4'd5; le_n = 1; ls_n = 4'h0; wd = pat(300); tick();
        chk_rd("R9 unqualified selects read", 5);
        // R8: global write overrides lane selects
        idle(); c_n = 0; a = 4'd5; ga_n = 0; le_n = 0; ls_n = 4'hF; wd = pat(301); tick();
        ref_mem[5] = pat(301);
        proc_rd(5);
        chk_rd("R8 global write all lanes", 5);

        // R10: deferred write after a processor start
        proc_rd(10);
        chk_rd("R10 proc start reads", 10);
        idle(); ga_n = 0; wd = pat(400); tick();
        ref_mem[10] = wd;
        chk_off("R10 deferred write no drive");
        idle(); st_n = 0; ga_n = 0; wd = pat(401); tick();
        ref_mem[11] = wd;
        proc_rd(10); chk_rd("R10 suspend write", 10);
        proc_rd(11); chk_rd("R10 continue write", 11);

        // R3: processor strobe ignored when primary select high
        proc_rd(4);
        idle(); p_n = 0; cs_n = 1; st_n = 0; tick();
        chk_rd("R3 ignored proc acts as continue", 5);
        idle(); p_n = 0; cs_n = 1; c_n = 0; tick();
        chk_off("R3 ctrl deselect");

        // R4: bank deselects, then continue cycles do nothing
        proc_rd(6);
        idle(); c_n = 0; bk_n = 1; a = 4'd12; tick();
        chk_off("R4 bank_sel_n high deselect");
        idle(); st_n = 0; tick();
        chk_off("R4 continue after deselect");
        idle(); st_n = 0; ga_n = 0; wd = 36'hF_FFFF_FFFF; tick();
        chk_off("R4 write after deselect");
        proc_rd(7); chk_rd("R4 no write while deselected", 7);
        proc_rd(8); chk_rd("R4 no write while deselected", 8);
        idle(); p_n = 0; bk = 0; tick();
        chk_off("R4 bank_sel low deselect");

        // R11: asynchronous output enable
        proc_rd(8);
        oe_n = 1; #2;
        chk_off("R11 out_en_n high");
        oe_n = 0; #2;
        chk_rd("R11 out_en_n low again", 8);

        // R12: sleep holds state and blocks writes
        lin = 1;
        proc_rd(2);
        chk_rd("R12 before sleep", 2);
        idle(); slp = 1; c_n = 0; a = 4'd3; ga_n = 0; wd = 36'h0; tick();
        chk_off("R12 sleep no drive");
        slp = 0; #2;
        chk_off("R12 no drive after sleep");
        idle(); st_n = 0; tick();
        chk_rd("R12 held address then step", 3);

        idle(); tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule